// File: doc/BRIEF.md
# Self-Clocked Serial Bit Receiver

This block recovers data bits from a single wire whose timing is carried by the data itself. A much faster master clock samples the wire. Every bit has a transition in its middle: a rise gives a 1 and a fall gives a 0. Any transition between two bits only sets up the level for the next middle transition, and the receiver discards it.

A message begins with a lone pulse. The width of that pulse gives the first bit period, which must be between 50 and 1000 master clock cycles. From then on, each mid-bit interval updates the period that the receiver tracks. Each decoded bit comes out with a one-cycle strobe. Once `2**n` bits have arrived, the whole word is presented with a one-cycle done pulse.

If the wire stays at one level for too long during a message, the receiver treats this as a break. It drops the partial word, raises a one-cycle break pulse and waits for a new pulse. When the select input is HIGH, the receiver ignores the wire entirely.

Data flows out only, and there is no ready input. The wire cannot be paused, so there is no back-pressure. `word_data` holds its value from one done pulse until the next one, which gives a consumer at least `2**n` bit periods to take the word.

Top module: `selfclk_rx`

## Requirements
- R1: While `rst_n` is LOW, `bit_valid`, `word_valid` and `brk_pulse` are 0 and `word_data` is all zeros.
- R2: A start pulse is accepted only if the time between its two edges is between 50 and 1000 clock cycles, inclusive. A pulse outside that range produces no bits.
- R3: After a start pulse is accepted, every transition that arrives at least three quarters of the tracked period after the previous mid-bit transition is a mid-bit transition. The receiver emits one bit for it: 1 for a rise, 0 for a fall, with `bit_valid` HIGH for one cycle. Earlier transitions produce nothing.
- R4: When bit number `2**n` of a message is emitted, `word_valid` is HIGH in that same cycle, for one cycle. In the same cycle, `word_data[2**n-1:0]` holds the bits with the first received bit at position `2**n-1`, and all higher bits are 0. `word_data` changes only on such a pulse or on reset.
- R5: `size_log` (n) is sampled when the start pulse is accepted and is clamped to the range 3 to 10. For example, a value of 1 gives 8-bit words.
- R6: During a message, if the wire holds one level for 1.5 times the tracked period, `brk_pulse` is HIGH for exactly one cycle. The partial word is dropped: no `word_valid`, and `word_data` is unchanged. The receiver then waits for a new start pulse, and a following message decodes correctly.
- R7: While `cfg_sel` is HIGH, the wire is ignored: no `bit_valid`, `word_valid` or `brk_pulse`. Any message in progress is abandoned without a break pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset to the power-on state |
| cfg_sel | input | 1 | HIGH disables reception; LOW enables it |
| rx_line | input | 1 | Self-clocked serial wire, asynchronous to `clk` |
| size_log | input | 4 | n; the word length is `2**n` bits |
| bit_data | output | 1 | Most recently recovered bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_data` |
| word_data | output | 1024 | Assembled word; the low `2**n` bits are meaningful |
| word_valid | output | 1 | One-cycle pulse when a word is complete |
| brk_pulse | output | 1 | One-cycle pulse when a break aborts a message |

## Verification
The hardest condition to create from the ports is a break in the middle of a message. It requires a valid start pulse, a few correctly timed bits, and then a level held for more than 1.5 tracked periods without being mistaken for a bit.

The bench builds the wire waveform itself. It stops sending partway through a message and holds the last level. It then checks that the break pulse appears while the previous word stays unchanged, and that a following message decodes correctly. The acceptance window for the start pulse is probed at both ends: 1000 and 50 cycles must be accepted, while 49 and 1100 cycles must produce no bits.

// File: rtl/selfclk_rx_pkg.sv
package selfclk_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_PRE  = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;

  function automatic logic [3:0] clamp_log(input logic [3:0] n,
                                           input logic [3:0] lo,
                                           input logic [3:0] hi);
    if (n < lo) return lo;
    if (n > hi) return hi;
    return n;
  endfunction
endpackage

// File: rtl/selfclk_rx_sync.sv
module selfclk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] fill_q;
  logic            lvl, prev, warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else begin
      sh_q   <= {sh_q[STAGES-1:0], din};
      fill_q <= {fill_q[STAGES-1:0], 1'b1};
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
  assign warm = fill_q[STAGES];
  assign rise = warm & lvl & ~prev;
  assign fall = warm & ~lvl & prev;
endmodule

// File: rtl/selfclk_rx_timer.sv
module selfclk_rx_timer #(
  parameter int CNT_W = 10,
  parameter int RUN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             any_edge,
  input  logic             mid_clr,
  output logic [CNT_W-1:0] mid_cnt,
  output logic [RUN_W-1:0] run_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_cnt <= '0;
      run_cnt <= '0;
    end else if (!run_en) begin
      mid_cnt <= '0;
      run_cnt <= '0;
    end else begin
      if (mid_clr)           mid_cnt <= CNT_W'(1);
      else if (mid_cnt != '1) mid_cnt <= mid_cnt + CNT_W'(1);
      if (any_edge)          run_cnt <= RUN_W'(1);
      else if (run_cnt != '1) run_cnt <= run_cnt + RUN_W'(1);
    end
  end
endmodule

// File: rtl/selfclk_rx_assemble.sv
module selfclk_rx_assemble #(
  parameter int LOG_MAX = 10,
  localparam int W    = 1 << LOG_MAX,
  localparam int NB_W = LOG_MAX + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   n_log,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         abort,
  output logic         at_last,
  output logic [W-1:0] word_data,
  output logic         word_valid,
  output logic         bit_data,
  output logic         bit_valid
);
  logic [W-1:0]    acc_q;
  logic [NB_W-1:0] cnt_q;
  logic [3:0]      n_q;
  logic [NB_W-1:0] target;
  logic            last;

  assign target  = NB_W'(1) << n_q;
  assign at_last = (cnt_q + NB_W'(1)) == target;
  assign last    = shift_en & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      n_q        <= 4'd3;
      word_data  <= '0;
      word_valid <= 1'b0;
      bit_data   <= 1'b0;
      bit_valid  <= 1'b0;
    end else begin
      bit_valid  <= shift_en;
      word_valid <= last;
      if (shift_en) bit_data <= shift_bit;
      if (start) begin
        acc_q <= '0;
        cnt_q <= '0;
        n_q   <= n_log;
      end else if (abort) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (shift_en) begin
        if (last) begin
          word_data <= {acc_q[W-2:0], shift_bit};
          acc_q     <= '0;
          cnt_q     <= '0;
        end else begin
          acc_q <= {acc_q[W-2:0], shift_bit};
          cnt_q <= cnt_q + NB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/selfclk_rx.sv
module selfclk_rx
  import selfclk_rx_pkg::*;
#(
  parameter int LOG_MIN     = 3,
  parameter int LOG_MAX     = 10,
  parameter int CNT_W       = 10,
  parameter int MIN_PER     = 50,
  parameter int MAX_PER     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_sel,
  input  logic                     rx_line,
  input  logic [3:0]               size_log,
  output logic                     bit_data,
  output logic                     bit_valid,
  output logic [(1<<LOG_MAX)-1:0]  word_data,
  output logic                     word_valid,
  output logic                     brk_pulse
);
  localparam int RUN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] PMAX = CNT_W'(MAX_PER);

  rx_state_e        st_q, st_n;
  logic             rise, fall, any_edge, active;
  logic [CNT_W-1:0] mid_cnt, period_q, mid_thr;
  logic [RUN_W-1:0] run_cnt, brk_thr;
  logic             mid_clr, accept, shift_en, abort, brk_n, per_load, at_last;

  selfclk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .rise(rise), .fall(fall)
  );

  selfclk_rx_timer #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_en(active), .any_edge(any_edge),
    .mid_clr(mid_clr), .mid_cnt(mid_cnt), .run_cnt(run_cnt)
  );

  selfclk_rx_assemble #(.LOG_MAX(LOG_MAX)) u_asm (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .n_log(clamp_log(size_log, 4'(LOG_MIN), 4'(LOG_MAX))),
    .shift_en(shift_en), .shift_bit(rise), .abort(abort), .at_last(at_last),
    .word_data(word_data), .word_valid(word_valid),
    .bit_data(bit_data), .bit_valid(bit_valid)
  );

  assign active   = ~cfg_sel;
  assign any_edge = rise | fall;
  assign mid_thr  = period_q - (period_q >> 2);
  assign brk_thr  = {1'b0, period_q} + {2'b0, period_q[CNT_W-1:1]};

  always_comb begin
    st_n     = st_q;
    mid_clr  = 1'b0;
    accept   = 1'b0;
    shift_en = 1'b0;
    abort    = 1'b0;
    brk_n    = 1'b0;
    per_load = 1'b0;
    if (!active) begin
      st_n  = RX_HUNT;
      abort = (st_q == RX_DATA);
    end else begin
      case (st_q)
        RX_HUNT: begin
          if (any_edge) begin
            st_n    = RX_PRE;
            mid_clr = 1'b1;
          end
        end
        RX_PRE: begin
          if (any_edge) begin
            if (mid_cnt >= PMIN && mid_cnt <= PMAX) begin
              st_n     = RX_DATA;
              accept   = 1'b1;
              mid_clr  = 1'b1;
              per_load = 1'b1;
            end else begin
              st_n = RX_HUNT;
            end
          end else if (mid_cnt > PMAX) begin
            st_n = RX_HUNT;
          end
        end
        RX_DATA: begin
          if (run_cnt >= brk_thr) begin
            brk_n = 1'b1;
            abort = 1'b1;
            st_n  = RX_HUNT;
          end else if (any_edge && mid_cnt >= mid_thr) begin
            shift_en = 1'b1;
            mid_clr  = 1'b1;
            per_load = 1'b1;
            if (at_last) st_n = RX_HUNT;
          end
        end
        default: st_n = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RX_HUNT;
      period_q  <= PMAX;
      brk_pulse <= 1'b0;
    end else begin
      st_q      <= st_n;
      brk_pulse <= brk_n;
      if (per_load) period_q <= mid_cnt;
    end
  end
endmodule

// File: rtl/selfclk_rx_check.sv
module selfclk_rx_check (
  input logic clk,
  input logic rst_n,
  input logic cfg_sel,
  input logic bit_valid,
  input logic word_valid,
  input logic brk_pulse
);
  p_brk_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);
  p_brk_no_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> !word_valid);
  p_word_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  p_word_with_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> bit_valid);
  p_bit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && $past(cfg_sel)) |-> (!bit_valid && !word_valid && !brk_pulse));
endmodule

bind selfclk_rx selfclk_rx_check u_check (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .bit_valid(bit_valid),
  .word_valid(word_valid), .brk_pulse(brk_pulse)
);

// File: tb/selfclk_rx_test.sv
module selfclk_rx_test;
  localparam int W = 1024;

  typedef struct packed {
    logic [3:0]  n;
    logic [10:0] per;
    logic [63:0] pat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 11'd50,   64'hA5},
    '{4'd4, 11'd100,  64'h1234},
    '{4'd5, 11'd73,   64'hDEADBEEF},
    '{4'd6, 11'd50,   64'hF0E1D2C3B4A59687},
    '{4'd3, 11'd1000, 64'h3C},
    '{4'd1, 11'd64,   64'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_sel = 1'b0, rx_line = 1'b0;
  logic [3:0] size_log = 4'd3;
  logic bit_data, bit_valid, word_valid, brk_pulse;
  logic [W-1:0] word_data;

  int checks = 0, failures = 0;
  int nbits = 0, nwords = 0, nbrk = 0, brk_wide = 0;
  logic [W-1:0] cap_word = '0;
  logic brk_prev = 1'b0;

  always #2 clk = ~clk;

  selfclk_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .rx_line(rx_line),
    .size_log(size_log), .bit_data(bit_data), .bit_valid(bit_valid),
    .word_data(word_data), .word_valid(word_valid), .brk_pulse(brk_pulse)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) nbits++;
      if (word_valid) begin
        nwords++;
        cap_word = word_data;
      end
      if (brk_pulse) nbrk++;
      if (brk_pulse && brk_prev) brk_wide++;
      brk_prev = brk_pulse;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic send(input int nb, input int p, input logic [63:0] pat, input int nsend);
    wait_clk(20);
    rx_line = 1'b1;
    wait_clk(p);
    rx_line = 1'b0;
    for (int i = nb - 1; i >= nb - nsend; i--) begin
      wait_clk(p / 2);
      rx_line = ~pat[i];
      wait_clk(p - p / 2);
      rx_line = pat[i];
    end
    wait_clk(3 * p);
    if (rx_line) begin
      rx_line = 1'b0;
      wait_clk(1100);
    end
  endtask

  function automatic int eff_bits(input logic [3:0] n);
    if (n < 3) return 8;
    if (n > 10) return 1024;
    return 1 << n;
  endfunction

  function automatic logic [W-1:0] exp_word(input logic [63:0] pat, input int nb);
    logic [W-1:0] e = '0;
    for (int i = 0; i < nb && i < 64; i++) e[i] = pat[i];
    return e;
  endfunction

  initial begin
    wait_clk(200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int b0, w0, k0;
    logic [W-1:0] prev_word;
    wait_clk(5);
    check(!bit_valid && !word_valid && !brk_pulse, "R1 strobes in reset",
          {61'd0, bit_valid, word_valid, brk_pulse}, 64'd0);
    check(word_data == '0, "R1 word in reset", word_data[63:0], 64'd0);
    rst_n = 1'b1;
    wait_clk(10);

    for (int v = 0; v < NV; v++) begin
      int nb;
      nb = eff_bits(VECS[v].n);
      size_log = VECS[v].n;
      b0 = nbits; w0 = nwords; k0 = nbrk;
      send(nb, int'(VECS[v].per), VECS[v].pat, nb);
      check(nbits - b0 == nb, "R3 bit count", 64'(nbits - b0), 64'(nb));
      check(nwords - w0 == 1, "R4 word count", 64'(nwords - w0), 64'd1);
      check(cap_word == exp_word(VECS[v].pat, nb), "R4/R5 word value",
            cap_word[63:0], exp_word(VECS[v].pat, nb)[63:0]);
      check(nbrk == k0, "R6 no break on clean message", 64'(nbrk - k0), 64'd0);
      check(word_data == cap_word, "R4 word held", word_data[63:0], cap_word[63:0]);
    end

    // R6: break partway through a message
    size_log = 4'd3;
    prev_word = word_data;
    b0 = nbits; w0 = nwords; k0 = nbrk;
    send(8, 50, 64'hB2, 3);
    check(nbrk - k0 == 1, "R6 break pulse count", 64'(nbrk - k0), 64'd1);
    check(brk_wide == 0, "R6 break pulse width", 64'(brk_wide), 64'd0);
    check(nwords == w0, "R6 no word after break", 64'(nwords - w0), 64'd0);
    check(nbits - b0 == 3, "R6 bits before break", 64'(nbits - b0), 64'd3);
    check(word_data == prev_word, "R6 word unchanged", word_data[63:0], prev_word[63:0]);
    w0 = nwords;
    send(8, 50, 64'h5A, 8);
    check(nwords - w0 == 1 && cap_word == exp_word(64'h5A, 8), "R6 recovery",
          cap_word[63:0], 64'h5A);

    // R7: select HIGH ignores the wire
    cfg_sel = 1'b1;
    b0 = nbits; w0 = nwords; k0 = nbrk;
    send(8, 50, 64'hFF, 8);
    check(nbits == b0 && nwords == w0 && nbrk == k0, "R7 ignored while disabled",
          64'(nbits - b0 + nwords - w0 + nbrk - k0), 64'd0);
    check(word_data == exp_word(64'h5A, 8), "R7 word kept", word_data[63:0], 64'h5A);
    cfg_sel = 1'b0;
    wait_clk(5);
    w0 = nwords;
    send(8, 50, 64'h69, 8);
    check(nwords - w0 == 1 && cap_word == exp_word(64'h69, 8), "R7 resumes",
          cap_word[63:0], 64'h69);

    // R2: start pulse just below the minimum and above the maximum
    b0 = nbits;
    send(8, 49, 64'h96, 8);
    check(nbits == b0, "R2 short start rejected", 64'(nbits - b0), 64'd0);
    b0 = nbits;
    send(8, 1100, 64'h0, 0);
    check(nbits == b0, "R2 long start rejected", 64'(nbits - b0), 64'd0);

    // R1: reset after activity clears the word
    rst_n = 1'b0;
    wait_clk(3);
    check(word_data == '0 && !word_valid && !bit_valid, "R1 reset after use",
          word_data[63:0], 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule